// File: doc/BRIEF.md
# Board Interrupt Expander

This block gathers sixteen board-level interrupt lines into a single active-high, level-sensitive interrupt for a host processor. Each line is first brought into the block's clock domain through two flip-flops. A high level then latches a sticky pending bit. The parent interrupt is raised while any pending bit is also enabled.

The host reaches the block over a small 16-bit register bus with an address, a read strobe, a write strobe and write data. Read data is combinational from the address while the read strobe is high. The pending bits are cleared by writing ones. The enable mask cannot be written directly. Instead, one alias address sets enable bits and another clears them, and reading either alias returns the mask. A fourth address shows the synchronised input levels, unaffected by latching or masking.

Top module: `board_irq_expander`

## Requirements
- R1: While `rst_n` is low and after its release, the pending bits and the enable mask are all zero and `irq_o` is low.
- R2: A read at offset 0x18 returns the synchronised levels of `src_i`, bit n for line n. A change on `src_i` driven before rising edge k is first visible after rising edge k+1. The read does not depend on the mask or on the pending bits.
- R3: A line whose synchronised level is high sets its pending bit on the next rising edge. The bit stays set after the line falls. A read at offset 0x16 returns the pending bits.
- R4: A write at offset 0x16 clears each pending bit written with a one and leaves bits written with zero unchanged. If the synchronised level of a line is high in the same cycle, its bit stays set.
- R5: A write at offset 0x1A sets each enable bit written with a one and leaves the others unchanged. A read at offset 0x1A returns the enable mask.
- R6: A write at offset 0x1C clears each enable bit written with a one and leaves the others unchanged. A read at offset 0x1C returns the enable mask.
- R7: `irq_o` is high exactly while at least one bit is both pending and enabled.
- R8: Reads at any offset other than 0x16, 0x18, 0x1A and 0x1C return zero, and `rdata_o` is zero while `rd_en_i` is low. Writes at offset 0x18 or at any unmapped offset change no pending bit and no enable bit.
- R9: With all inputs low, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves the mask zero, the pending bits zero and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Asynchronous interrupt lines, one per source |
| addr_i | input | ADDR_W | Byte offset of the register access |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Parent interrupt, active high, level |

## Verification
A line driven before edge k appears in the raw view after edge k+1 and in the pending bits after edge k+2. A mask or clear write lands on the edge that samples it. `irq_o` and read data follow their registers with no further delay. The bench keeps a cycle model that advances on each rising edge. It drives stimulus at the falling edge and compares read data and `irq_o` one time unit later, so every comparison sees exactly the registers updated by the previous edge. Directed sequences count edges explicitly to check the two-edge raw latency and the clear-while-high case.

// File: rtl/board_irq_expander.sv
module board_irq_expander #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(8'h16);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] OFS_SET  = ADDR_W'(8'h1A);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(8'h1C);

  logic [15:0] meta_q, lvl_q, pend_q, en_q;
  logic [15:0] pend_wipe, en_add, en_drop;

  assign pend_wipe = (wr_en_i && addr_i == OFS_PEND) ? wdata_i : 16'h0;
  assign en_add    = (wr_en_i && addr_i == OFS_SET)  ? wdata_i : 16'h0;
  assign en_drop   = (wr_en_i && addr_i == OFS_CLR)  ? wdata_i : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 16'h0;
      lvl_q  <= 16'h0;
      pend_q <= 16'h0;
      en_q   <= 16'h0;
    end else begin
      meta_q <= src_i;
      lvl_q  <= meta_q;
      pend_q <= (pend_q & ~pend_wipe) | lvl_q;
      en_q   <= (en_q | en_add) & ~en_drop;
    end
  end

  always_comb begin
    rdata_o = 16'h0;
    if (rd_en_i) begin
      case (addr_i)
        OFS_PEND:         rdata_o = pend_q;
        OFS_RAW:          rdata_o = lvl_q;
        OFS_SET, OFS_CLR: rdata_o = en_q;
        default:          rdata_o = 16'h0;
      endcase
    end
  end

  assign irq_o = |(pend_q & en_q);

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i))); // R5
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_CLR) |=> ((en_q & $past(wdata_i)) == 16'h0)); // R6
  AST_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != 16'h0) |=> ((pend_q & $past(lvl_q)) == $past(lvl_q))); // R4
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_RAW) |=> $stable(en_q)); // R8
  AST_FULL_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_CLR && wdata_i == 16'hFFFF) |=> !irq_o); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en_i && addr_i == OFS_PEND)) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

endmodule

// File: tb/test_board_irq_expander.sv
module test_board_irq_expander;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic [7:0] addr_i = '0;
  logic rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  board_irq_expander #(.ADDR_W(8)) i_board_irq_expander (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] m_s1, m_s2, m_pend, m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_en <= '0;
    end else begin
      m_s1 <= src_i;
      m_s2 <= m_s1;
      m_pend <= (m_pend & ~((wr_en_i && addr_i == 8'h16) ? wdata_i : 16'h0)) | m_s2;
      m_en <= (m_en | ((wr_en_i && addr_i == 8'h1A) ? wdata_i : 16'h0))
              & ~((wr_en_i && addr_i == 8'h1C) ? wdata_i : 16'h0);
    end
  end

  function automatic logic [15:0] exp_rd(logic [7:0] a, logic rd);
    if (!rd) return 16'h0;
    case (a)
      8'h16: return m_pend;
      8'h18: return m_s2;
      8'h1A, 8'h1C: return m_en;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] a, logic rd);
    if (!rd) return "R8";
    case (a)
      8'h16: return "R3";
      8'h18: return "R2";
      8'h1A: return "R5";
      8'h1C: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [15:0] s, logic [7:0] a, logic rd, logic wr, logic [15:0] d);
    @(negedge clk);
    src_i = s; addr_i = a; rd_en_i = rd; wr_en_i = wr; wdata_i = d;
    #1;
    chk(req_of(a, rd), rdata_o, exp_rd(a, rd));
    chk("R7", {15'h0, irq_o}, {15'h0, |(m_pend & m_en)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {15'h0, irq_o}, 16'h0);
    rst_n = 1'b1;
    step(16'h0, 8'h16, 1, 0, 0); chk("R1", rdata_o, 16'h0);
    step(16'h0, 8'h1A, 1, 0, 0); chk("R1", rdata_o, 16'h0);

    // R2: two-edge raw latency
    step(16'h0008, 8'h18, 1, 0, 0);
    step(16'h0008, 8'h18, 1, 0, 0); chk("R2", rdata_o, 16'h0);
    step(16'h0008, 8'h18, 1, 0, 0); chk("R2", rdata_o, 16'h0008);
    // R3: sticky after drop
    step(16'h0000, 8'h16, 1, 0, 0); chk("R3", rdata_o, 16'h0008);
    repeat (3) step(16'h0, 8'h16, 1, 0, 0);
    chk("R3", rdata_o, 16'h0008);
    // R7: enable raises irq
    step(16'h0, 8'h1A, 1, 1, 16'h0008);
    step(16'h0, 8'h1A, 1, 0, 0); chk("R7", {15'h0, irq_o}, 16'h1);
    // R4: clear with zeros no effect, ones clear
    step(16'h0, 8'h16, 1, 1, 16'hFFF7);
    step(16'h0, 8'h16, 1, 0, 0); chk("R4", rdata_o, 16'h0008);
    step(16'h0, 8'h16, 1, 1, 16'h0008);
    step(16'h0, 8'h16, 1, 0, 0); chk("R4", rdata_o, 16'h0);
    chk("R7", {15'h0, irq_o}, 16'h0);
    // R4: clear while line held high
    repeat (3) step(16'h0020, 8'h16, 1, 0, 0);
    step(16'h0020, 8'h16, 1, 1, 16'hFFFF);
    step(16'h0020, 8'h16, 1, 0, 0); chk("R4", rdata_o, 16'h0020);
    // R8: writes to raw and unmapped ignored
    step(16'h0, 8'h18, 0, 1, 16'hFFFF);
    step(16'h0, 8'h40, 0, 1, 16'hFFFF);
    step(16'h0, 8'h1C, 1, 0, 0); chk("R8", rdata_o, 16'h0008);
    step(16'h0, 8'h14, 1, 0, 0); chk("R8", rdata_o, 16'h0);
    // R9: initialisation sequence
    step(16'h0, 8'h1A, 0, 1, 16'hA5A5);
    repeat (3) step(16'h0, 8'h00, 0, 0, 0);
    step(16'h0, 8'h1C, 0, 1, 16'hFFFF);
    step(16'h0, 8'h16, 0, 1, 16'hFFFF);
    step(16'h0, 8'h16, 1, 0, 0); chk("R9", rdata_o, 16'h0);
    step(16'h0, 8'h1C, 1, 0, 0); chk("R9", rdata_o, 16'h0);
    chk("R9", {15'h0, irq_o}, 16'h0);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] s;
      logic [7:0] a;
      int pick;
      s = 16'($urandom) & 16'($urandom) & 16'($urandom);
      pick = int'($urandom % 6);
      case (pick)
        0: a = 8'h16;
        1: a = 8'h18;
        2: a = 8'h1A;
        3: a = 8'h1C;
        default: a = 8'($urandom);
      endcase
      step(s, a, 1'($urandom), ($urandom % 3) == 0, 16'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule